// File: doc/BRIEF.md
# Dual-Order Four-Beat Burst Address Generator

This block produces the address for each beat of a four-beat memory burst. A burst begins when either of two address strobes, one for the processor side and one for the controller side, is high at a rising clock edge. At that edge the block captures the incoming address and the order select. Each later edge that sees the advance input high moves the two least significant address bits to the next burst position. The other address bits are passed through from the captured start address without change.

Two beat orders are available. The interleaved order forms each beat's low bits as the start low bits XOR the beat index. The linear order counts the low bits upward modulo four from the start value. The order is fixed for the whole burst at the edge that starts it. The block sits between a bus interface and a memory array. It has no storage of its own apart from the captured start and the beat index.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, burst_addr is all zeros, the beat index is zero and the captured order is linear.
- R2: When proc_strobe or ctrl_strobe is high at a rising edge, burst_addr equals the addr_in sampled at that edge from that edge onward. This is beat 0 of a new burst.
- R3: With order_sel = 1 captured (interleaved), beat k (k = 0..3) drives burst_addr[1:0] = start[1:0] XOR k. For example, start 01 gives 01, 00, 11, 10.
- R4: With order_sel = 0 captured (linear), beat k drives burst_addr[1:0] = (start[1:0] + k) mod 4. For example, start 11 gives 11, 00, 01, 10.
- R5: An edge with advance high and both strobes low moves to the next beat. An edge with all three low leaves burst_addr unchanged.
- R6: When a strobe and advance are both high at the same edge, the strobe wins: the new addr_in is loaded as beat 0.
- R7: burst_addr[ADDR_W-1:2] keeps the captured start value for the whole burst and never takes a carry from the low two bits.
- R8: After four advances the beat index wraps, and burst_addr returns to the start address.
- R9: order_sel is sampled only at a strobe edge. Changing it in the middle of a burst does not affect the remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_strobe | input | 1 | Processor-side burst start strobe |
| ctrl_strobe | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order; sampled at a strobe |
| addr_in | input | ADDR_W | Start address offered with a strobe |
| burst_addr | output | ADDR_W | Address of the current beat |

## Verification
Every result of this block appears one edge after the stimulus that causes it. The captured start, the captured order and the beat index are registers, and burst_addr is a combinational function of them. The bench applies inputs on the falling edge and updates its own model at the following rising edge. It then compares burst_addr on the next falling edge, so each check sees the result of exactly one edge. The bound checker uses the same one-edge relation, written with |=>.

// File: rtl/burst_pkg.sv
// Package: shared constants and types for the burst address generator.
// Assumes: bursts are always four beats, so the beat index is two bits.
package burst_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/burst_start_capture.sv
// Module: burst_start_capture
// Holds the start address and the beat order of the current burst.
// Assumes: start is the OR of both strobes and is computed by the parent.
module burst_start_capture
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] start_addr,
    output order_e            order_q
);

    // Capture the start address and the order on a strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            order_q    <= ORDER_LINEAR;
        end else if (start) begin
            start_addr <= addr_in;
            order_q    <= order_e'(order_sel);
        end
    end

endmodule

// File: rtl/burst_beat_counter.sv
// Module: burst_beat_counter
// Two-bit wrapping beat index. A start clears it; an advance steps it.
// Assumes: start has priority over advance.
module burst_beat_counter
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  advance,
    output beat_t beat
);

    // Clear on a start, otherwise step modulo four on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (start) begin
            beat <= '0;
        end else if (advance) begin
            beat <= beat + beat_t'(1);
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Combinational map from the start low bits and the beat index to the
// low bits of the beat address, in either order.
// Assumes: purely combinational; the order does not change within a burst.
module burst_order_map
    import burst_pkg::*;
(
    input  beat_t  start_low,
    input  beat_t  beat,
    input  order_e order,
    output beat_t  low_out
);

    beat_t lin_low;
    beat_t ilv_low;

    // Form the interleaved low bits one bit at a time.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_low[b] ^ beat[b];
    end

    // Form the linear low bits by adding modulo four.
    always_comb begin
        lin_low = start_low + beat;
    end

    // Pick the order that was captured for this burst.
    always_comb begin
        low_out = (order == ORDER_INTERLEAVED) ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Burst address generator with two start strobes, an advance input and a
// selectable beat order. burst_addr is valid one edge after its cause.
// Assumes: ADDR_W > 2; the upper bits never take a carry from the counter.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] burst_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              start;
    logic [ADDR_W-1:0] start_addr;
    order_e            order_q;
    beat_t             beat;
    beat_t             low_bits;

    // Either strobe starts a burst.
    always_comb begin
        start = proc_strobe | ctrl_strobe;
    end

    burst_start_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .addr_in    (addr_in),
        .order_sel  (order_sel),
        .start_addr (start_addr),
        .order_q    (order_q)
    );

    burst_beat_counter u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .advance (advance),
        .beat    (beat)
    );

    burst_order_map u_map (
        .start_low (start_addr[BEAT_W-1:0]),
        .beat      (beat),
        .order     (order_q),
        .low_out   (low_bits)
    );

    // Join the held upper bits to the sequenced low bits.
    always_comb begin
        burst_addr = {start_addr[ADDR_W-1 -: HI_W], low_bits};
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Property checker bound to burst_addr_gen.
// Assumes: inputs are driven to known values from time zero.
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strobe,
    input logic              ctrl_strobe,
    input logic              advance,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] burst_addr,
    input order_e            order_q
);

    logic strobe;
    assign strobe = proc_strobe | ctrl_strobe;

    // R2 and R6: a strobe loads addr_in, whatever advance does.
    assert_strobe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> burst_addr == $past(addr_in));

    // R5: with no strobe and no advance the address holds.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !advance) |=> $stable(burst_addr));

    // R7: an advance never changes the upper bits.
    assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && advance) |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2]));

    // R4: in linear order an advance adds one to the low bits.
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && advance && order_q == ORDER_LINEAR)
        |=> burst_addr[1:0] == $past(burst_addr[1:0]) + 2'd1);

    // R3: in interleaved order an advance always changes the low bits.
    assert_ilv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && advance && order_q == ORDER_INTERLEAVED)
        |=> burst_addr[1:0] != $past(burst_addr[1:0]));

    // R9: the captured order holds while no strobe arrives.
    assert_order_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(order_q));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .advance     (advance),
    .addr_in     (addr_in),
    .burst_addr  (burst_addr),
    .order_q     (order_q)
);

// File: tb/burst_addr_gen_bench.sv
// Bench for burst_addr_gen: directed corner cases, then seeded random stimulus.
module burst_addr_gen_bench;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_strobe = 1'b0;
    logic          ctrl_strobe = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] burst_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state, updated from the requirements.
    logic [AW-1:0] m_start = '0;
    logic          m_ilv = 1'b0;
    logic [1:0]    m_beat = '0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .advance     (advance),
        .order_sel   (order_sel),
        .addr_in     (addr_in),
        .burst_addr  (burst_addr)
    );

    // Expected address: R3 interleaved XOR, R4 linear add, R7 upper bits kept.
    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
        return {m_start[AW-1:2], lo};
    endfunction

    task automatic check(input logic [AW-1:0] exp, input string tag);
        checks++;
        if (burst_addr !== exp) begin
            errors++;
            $display("FAIL %s: burst_addr=%h expected=%h", tag, burst_addr, exp);
        end
    endtask

    // Apply one cycle of inputs at a falling edge and check at the next one.
    task automatic cycle(input logic ps, input logic cs, input logic adv,
                         input logic osel, input logic [AW-1:0] a, input string tag);
        proc_strobe = ps; ctrl_strobe = cs; advance = adv;
        order_sel = osel; addr_in = a;
        @(posedge clk);
        if (ps || cs) begin
            m_start = a; m_ilv = osel; m_beat = '0;
        end else if (adv) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check(exp_addr(), tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        @(negedge clk);
        @(negedge clk);
        check('0, "R1 in reset");
        rst_n = 1'b1;
        cycle(0, 0, 0, 0, '0, "R1 after reset");

        // R3: interleaved, start low 01 -> 01,00,11,10 then wrap (R8).
        base = 17'h0A5C1;
        cycle(1, 0, 0, 1, base, "R2 proc strobe load");
        if (burst_addr[1:0] !== 2'b01) begin errors++; $display("FAIL R3: low=%b expected=01", burst_addr[1:0]); end
        checks++;
        cycle(0, 0, 1, 1, '0, "R3 beat1");
        cycle(0, 0, 1, 1, '0, "R3 beat2");
        cycle(0, 0, 1, 1, '0, "R3 beat3");
        cycle(0, 0, 1, 1, '0, "R8 wrap to start");
        checks++;
        if (burst_addr !== base) begin errors++; $display("FAIL R8: burst_addr=%h expected=%h", burst_addr, base); end

        // R4 and R7: linear, start low 11 -> 11,00,01,10 with no upper carry.
        base = 17'h1FFFF;
        cycle(0, 1, 0, 0, base, "R2 ctrl strobe load");
        cycle(0, 0, 1, 0, '0, "R4 R7 beat1 no carry");
        checks++;
        if (burst_addr !== 17'h1FFFC) begin errors++; $display("FAIL R7: burst_addr=%h expected=1fffc", burst_addr); end
        cycle(0, 0, 0, 0, '0, "R5 hold without advance");
        cycle(0, 0, 1, 1, '0, "R9 order change ignored");
        checks++;
        if (burst_addr[1:0] !== 2'b01) begin errors++; $display("FAIL R9: low=%b expected=01", burst_addr[1:0]); end
        cycle(0, 0, 1, 1, '0, "R4 beat3");

        // R6: strobe and advance together load a new start.
        cycle(1, 0, 1, 0, 17'h00102, "R6 strobe beats advance");
        checks++;
        if (burst_addr !== 17'h00102) begin errors++; $display("FAIL R6: burst_addr=%h expected=00102", burst_addr); end

        // Random traffic with a fixed seed.
        void'($urandom(32'd7741));
        for (int i = 0; i < 400; i++) begin
            logic r_ps, r_cs;
            r_ps = ($urandom % 8) == 0;
            r_cs = ($urandom % 8) == 0;
            cycle(r_ps, r_cs, $urandom % 2, $urandom % 2, AW'($urandom),
                  "R2 R3 R4 R5 R6 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule